// File: doc/BRIEF.md
# VSYNC Genlock Controller

This block keeps a display timing generator in step with an external video stream. It watches the vertical sync of the incoming video and the vertical sync of the local display, both already synchronous to one 27 MHz clock. A programmable number of clocks after a chosen edge of the incoming sync, it issues a one-cycle restart pulse that tells the display timing generator to begin a new frame. If the display's own chosen sync edge lands on that same clock, the display is already aligned and the pulse is withheld.

Locking can run on every incoming frame (continuous) or just once after software enables it (single-shot). Single-shot takes priority over continuous. A separate watchdog measures the gap after each incoming sync edge against one of two 16-bit limits, chosen by the current field (odd or even). When the gap runs out it raises a sticky flag for that field, which software clears by writing 1. Configuration uses a flat word-wide write/read port. All settings come out of reset at zero, so locking and timeouts start disabled.

Top module: `vsync_genlock`

## Requirements
- R1: After reset, `restart_o`, `odd_timeout_o` and `even_timeout_o` are 0 and every register address reads 0.
- R2: When a lock is armed by an incoming sync edge seen at clock edge k, with delay value D (address 1, bits [20:0]), `restart_o` is high for exactly the cycle that follows clock edge k+D+1.
- R3: The incoming sync edge that arms a lock is the rising edge when mode bit 2 is 0 and the falling edge when it is 1.
- R4: The restart pulse is withheld if the display sync's selected edge (mode bit 3: 0 rising, 1 falling) is seen on the same clock edge that would register the pulse. The pending lock is consumed either way.
- R5: With continuous mode (mode bit 0) set and single-shot clear, every selected incoming edge arms a lock. An edge that arrives while a count is pending restarts the count from D.
- R6: With single-shot (mode bit 1) set, only the first selected incoming edge after the bit was last written from 0 to 1 arms a lock, whatever the continuous bit holds. Clearing and setting the bit again re-arms it.
- R7: When mode bits 0 and 1 are both 0, no restart pulse is produced, and a count that is already pending is discarded.
- R8: When the timeout enable (mode bit 4) is 0, neither timeout flag is ever set.
- R9: With timeout enabled, if no selected incoming edge follows edge k within L+1 clock edges, the flag for the current field is set at edge k+L+1. L is taken from address 2: bits [15:0] when `field_odd_i` is 1, bits [31:16] when it is 0. The odd flag drives `odd_timeout_o` and reads at mode bit 16. The even flag drives `even_timeout_o` and reads at mode bit 17.
- R10: Writing address 0 with bit 16 or 17 at 1 clears the matching flag, unless the flag is being set on that same clock. Writing 0 to those bits leaves the flags unchanged.
- R11: Address 0 holds the mode bits 4:0. Address 1 holds the 21-bit delay. Address 2 holds both limits. Unused bits read 0, and writes take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_vsync_i | input | 1 | Incoming video vertical sync |
| disp_vsync_i | input | 1 | Display timing generator vertical sync |
| field_odd_i | input | 1 | Current field is odd (1) or even (0) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_waddr_i | input | 2 | Register write address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_raddr_i | input | 2 | Register read address |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| restart_o | output | 1 | One-cycle frame restart pulse to the display timing generator |
| odd_timeout_o | output | 1 | Sticky odd-field timeout flag |
| even_timeout_o | output | 1 | Sticky even-field timeout flag |

## Verification
An incoming sync edge seen at clock edge k shows up on `restart_o` after edge k+D+1, and a timeout flag rises after edge k+L+1. Register writes become visible one clock after the write strobe, and reads return the value in the same cycle. The bench model records the edge number at which each event is due, rather than copying the counters. It compares all three outputs half a clock after every edge, so each due time is checked to the exact cycle. Register readback is sampled shortly after a falling edge, once the read address has settled.

// File: rtl/genlock_pkg.sv
package genlock_pkg;

    localparam int REG_W = 32;

    // register addresses
    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_DELAY = 2'd1;
    localparam logic [1:0] A_LIMIT = 2'd2;

    // bit positions inside the mode word
    localparam int B_CONT    = 0;
    localparam int B_SINGLE  = 1;
    localparam int B_VFALL   = 2;
    localparam int B_DFALL   = 3;
    localparam int B_TEN     = 4;
    localparam int B_ODD_TO  = 16;
    localparam int B_EVEN_TO = 17;

    // lsb of the even-field limit inside the limit word
    localparam int LIM_EVEN_LSB = 16;

    // sync sources handled by the edge detectors
    localparam int N_SRC    = 2;
    localparam int SRC_VID  = 0;
    localparam int SRC_DISP = 1;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      tout_en;
        edge_sel_e disp_edge;
        edge_sel_e vid_edge;
        logic      single_en;
        logic      cont_en;
    } mode_t;

    typedef struct packed {
        logic odd;
        logic even;
    } to_flags_t;

    function automatic logic edge_hit(input logic prev, input logic cur, input edge_sel_e sel);
        return (sel == EDGE_FALL) ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/gl_edge_det.sv
module gl_edge_det
    import genlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_i,
    input  edge_sel_e sel_i,
    output logic      hit_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_i;
    end

    assign hit_o = edge_hit(prev_q, sig_i, sel_i);

endmodule

// File: rtl/gl_regs.sv
module gl_regs
    import genlock_pkg::*;
#(
    parameter int DELAY_W = 21,
    parameter int TOUT_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [1:0]         waddr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [1:0]         raddr_i,
    output logic [REG_W-1:0]   rdata_o,
    input  to_flags_t          flags_i,
    output mode_t              mode_o,
    output logic [DELAY_W-1:0] delay_o,
    output logic [TOUT_W-1:0]  lim_odd_o,
    output logic [TOUT_W-1:0]  lim_even_o,
    output to_flags_t          clr_o
);

    mode_t              mode_q;
    logic [DELAY_W-1:0] delay_q;
    logic [TOUT_W-1:0]  lim_odd_q;
    logic [TOUT_W-1:0]  lim_even_q;
    logic               wdata_unused;

    assign wdata_unused = ^wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            delay_q    <= '0;
            lim_odd_q  <= '0;
            lim_even_q <= '0;
        end else if (we_i) begin
            case (waddr_i)
                A_MODE: begin
                    mode_q.cont_en   <= wdata_i[B_CONT];
                    mode_q.single_en <= wdata_i[B_SINGLE];
                    mode_q.vid_edge  <= edge_sel_e'(wdata_i[B_VFALL]);
                    mode_q.disp_edge <= edge_sel_e'(wdata_i[B_DFALL]);
                    mode_q.tout_en   <= wdata_i[B_TEN];
                end
                A_DELAY: delay_q <= wdata_i[DELAY_W-1:0];
                A_LIMIT: begin
                    lim_odd_q  <= wdata_i[TOUT_W-1:0];
                    lim_even_q <= wdata_i[LIM_EVEN_LSB +: TOUT_W];
                end
                default: ;
            endcase
        end
    end

    assign clr_o.odd  = we_i && (waddr_i == A_MODE) && wdata_i[B_ODD_TO];
    assign clr_o.even = we_i && (waddr_i == A_MODE) && wdata_i[B_EVEN_TO];

    always_comb begin
        rdata_o = '0;
        case (raddr_i)
            A_MODE: begin
                rdata_o[B_CONT]    = mode_q.cont_en;
                rdata_o[B_SINGLE]  = mode_q.single_en;
                rdata_o[B_VFALL]   = (mode_q.vid_edge == EDGE_FALL);
                rdata_o[B_DFALL]   = (mode_q.disp_edge == EDGE_FALL);
                rdata_o[B_TEN]     = mode_q.tout_en;
                rdata_o[B_ODD_TO]  = flags_i.odd;
                rdata_o[B_EVEN_TO] = flags_i.even;
            end
            A_DELAY: rdata_o[DELAY_W-1:0] = delay_q;
            A_LIMIT: begin
                rdata_o[TOUT_W-1:0]            = lim_odd_q;
                rdata_o[LIM_EVEN_LSB +: TOUT_W] = lim_even_q;
            end
            default: ;
        endcase
    end

    assign mode_o     = mode_q;
    assign delay_o    = delay_q;
    assign lim_odd_o  = lim_odd_q;
    assign lim_even_o = lim_even_q;

endmodule

// File: rtl/gl_lock_ctrl.sv
module gl_lock_ctrl #(
    parameter int DELAY_W = 21
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cont_en_i,
    input  logic               single_en_i,
    input  logic               vid_hit_i,
    input  logic               disp_hit_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               restart_o
);

    logic               pend_q;
    logic               used_q;
    logic [DELAY_W-1:0] cnt_q;
    logic               lock_on;
    logic               allow;
    logic               arm;
    logic               fire;

    assign lock_on = cont_en_i | single_en_i;
    // single-shot overrides continuous
    assign allow   = single_en_i ? ~used_q : cont_en_i;
    assign arm     = vid_hit_i & allow;
    assign fire    = pend_q & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            used_q    <= 1'b0;
            cnt_q     <= '0;
            restart_o <= 1'b0;
        end else begin
            restart_o <= fire & ~disp_hit_i & lock_on;

            if (!single_en_i) used_q <= 1'b0;
            else if (arm)     used_q <= 1'b1;

            if (!lock_on) begin
                pend_q <= 1'b0;
            end else if (arm) begin
                pend_q <= 1'b1;
                cnt_q  <= delay_i;
            end else if (fire) begin
                pend_q <= 1'b0;
            end else if (pend_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4
    aligned_skip_chk: assert property (@(posedge clk) disable iff (rst)
        disp_hit_i |=> !restart_o);

    // R5
    arm_load_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (pend_q && cnt_q == $past(delay_i)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cont_en_i && !single_en_i) |=> !restart_o);

endmodule

// File: rtl/gl_timeout_mon.sv
module gl_timeout_mon
    import genlock_pkg::*;
#(
    parameter int TOUT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tout_en_i,
    input  logic              vid_hit_i,
    input  logic              field_odd_i,
    input  logic [TOUT_W-1:0] lim_odd_i,
    input  logic [TOUT_W-1:0] lim_even_i,
    input  to_flags_t         clr_i,
    output to_flags_t         flags_o
);

    logic              run_q;
    logic [TOUT_W-1:0] tcnt_q;
    logic [TOUT_W-1:0] lim_sel;
    logic              expire;

    assign lim_sel = field_odd_i ? lim_odd_i : lim_even_i;
    assign expire  = tout_en_i & run_q & ~vid_hit_i & (tcnt_q == lim_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            tcnt_q <= '0;
        end else if (!tout_en_i) begin
            run_q <= 1'b0;
        end else if (vid_hit_i) begin
            run_q  <= 1'b1;
            tcnt_q <= '0;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            flags_o.odd  <= (flags_o.odd  & ~clr_i.odd)  | (expire &  field_odd_i);
            flags_o.even <= (flags_o.even & ~clr_i.even) | (expire & ~field_odd_i);
        end
    end

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !tout_en_i |=> (!$rose(flags_o.odd) && !$rose(flags_o.even)));

    // R9
    odd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_o.odd && !clr_i.odd) |=> flags_o.odd);

    // R10
    odd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i.odd && !(expire && field_odd_i)) |=> !flags_o.odd);

    // R10
    even_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i.even && !(expire && !field_odd_i)) |=> !flags_o.even);

endmodule

// File: rtl/vsync_genlock.sv
module vsync_genlock
    import genlock_pkg::*;
#(
    parameter int DELAY_W = 21,
    parameter int TOUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vid_vsync_i,
    input  logic             disp_vsync_i,
    input  logic             field_odd_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_waddr_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    input  logic [1:0]       cfg_raddr_i,
    output logic [REG_W-1:0] cfg_rdata_o,
    output logic             restart_o,
    output logic             odd_timeout_o,
    output logic             even_timeout_o
);

    mode_t              mode;
    logic [DELAY_W-1:0] delay;
    logic [TOUT_W-1:0]  lim_odd;
    logic [TOUT_W-1:0]  lim_even;
    to_flags_t          flags;
    to_flags_t          clr;

    logic [N_SRC-1:0]   src_sig;
    logic [N_SRC-1:0]   src_hit;
    edge_sel_e          src_sel [N_SRC];

    assign src_sig[SRC_VID]  = vid_vsync_i;
    assign src_sig[SRC_DISP] = disp_vsync_i;
    assign src_sel[SRC_VID]  = mode.vid_edge;
    assign src_sel[SRC_DISP] = mode.disp_edge;

    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        gl_edge_det u_det (
            .clk   (clk),
            .rst   (rst),
            .sig_i (src_sig[g]),
            .sel_i (src_sel[g]),
            .hit_o (src_hit[g])
        );
    end

    gl_regs #(.DELAY_W(DELAY_W), .TOUT_W(TOUT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (cfg_we_i),
        .waddr_i    (cfg_waddr_i),
        .wdata_i    (cfg_wdata_i),
        .raddr_i    (cfg_raddr_i),
        .rdata_o    (cfg_rdata_o),
        .flags_i    (flags),
        .mode_o     (mode),
        .delay_o    (delay),
        .lim_odd_o  (lim_odd),
        .lim_even_o (lim_even),
        .clr_o      (clr)
    );

    gl_lock_ctrl #(.DELAY_W(DELAY_W)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .cont_en_i   (mode.cont_en),
        .single_en_i (mode.single_en),
        .vid_hit_i   (src_hit[SRC_VID]),
        .disp_hit_i  (src_hit[SRC_DISP]),
        .delay_i     (delay),
        .restart_o   (restart_o)
    );

    gl_timeout_mon #(.TOUT_W(TOUT_W)) u_tmon (
        .clk         (clk),
        .rst         (rst),
        .tout_en_i   (mode.tout_en),
        .vid_hit_i   (src_hit[SRC_VID]),
        .field_odd_i (field_odd_i),
        .lim_odd_i   (lim_odd),
        .lim_even_i  (lim_even),
        .clr_i       (clr),
        .flags_o     (flags)
    );

    assign odd_timeout_o  = flags.odd;
    assign even_timeout_o = flags.even;

endmodule

// File: tb/vsync_genlock_test.sv
`timescale 1ns/1ps
module vsync_genlock_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vid_vs = 1'b0;
    logic        disp_vs = 1'b0;
    logic        field_odd = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [1:0]  cfg_raddr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        restart;
    logic        odd_to;
    logic        even_to;

    always #2.5 clk = ~clk;

    vsync_genlock uut (
        .clk            (clk),
        .rst            (rst),
        .vid_vsync_i    (vid_vs),
        .disp_vsync_i   (disp_vs),
        .field_odd_i    (field_odd),
        .cfg_we_i       (cfg_we),
        .cfg_waddr_i    (cfg_addr),
        .cfg_wdata_i    (cfg_wdata),
        .cfg_raddr_i    (cfg_raddr),
        .cfg_rdata_o    (cfg_rdata),
        .restart_o      (restart),
        .odd_timeout_o  (odd_to),
        .even_timeout_o (even_to)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    pulses = 0;
    string req = "R1";

    // reference model state: event due times, not counters
    int cyc, due, tstart, m_delay, m_lo, m_le, lim;
    bit used, pv, pd, tarm, m_odd, m_even, exp_rst;
    bit m_cont, m_single, m_vf, m_df, m_ten;
    bit ve, de, lock, allow, fire, expire, cw;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0; due = -1; tstart = 0; m_delay = 0; m_lo = 0; m_le = 0;
            used = 0; pv = 0; pd = 0; tarm = 0; m_odd = 0; m_even = 0; exp_rst = 0;
            m_cont = 0; m_single = 0; m_vf = 0; m_df = 0; m_ten = 0;
        end else begin
            cyc++;
            ve    = m_vf ? (pv && !vid_vs) : (!pv && vid_vs);
            de    = m_df ? (pd && !disp_vs) : (!pd && disp_vs);
            lock  = m_cont || m_single;
            fire  = lock && (due == cyc) && !de;
            allow = m_single ? !used : m_cont;
            if (!lock) due = -1;
            else if (ve && allow) due = cyc + m_delay + 1;
            else if (due == cyc) due = -1;
            if (!m_single) used = 0;
            else if (ve && !used) used = 1;

            lim    = field_odd ? m_lo : m_le;
            expire = m_ten && tarm && !ve && (cyc - 1 - tstart == lim);
            if (!m_ten) tarm = 0;
            else if (ve) begin tarm = 1; tstart = cyc; end
            else if (expire) tarm = 0;

            cw     = cfg_we && (cfg_addr == 2'd0);
            m_odd  = (m_odd  && !(cw && cfg_wdata[16])) || (expire && field_odd);
            m_even = (m_even && !(cw && cfg_wdata[17])) || (expire && !field_odd);
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin
                        m_cont = cfg_wdata[0]; m_single = cfg_wdata[1];
                        m_vf = cfg_wdata[2]; m_df = cfg_wdata[3]; m_ten = cfg_wdata[4];
                    end
                    2'd1: m_delay = int'(cfg_wdata[20:0]);
                    2'd2: begin m_lo = int'(cfg_wdata[15:0]); m_le = int'(cfg_wdata[31:16]); end
                    default: ;
                endcase
            end
            exp_rst = fire;
            pv = vid_vs;
            pd = disp_vs;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(restart === exp_rst, {req, " restart"}, {31'd0, restart}, {31'd0, exp_rst});
            check(odd_to === m_odd, {req, " odd flag"}, {31'd0, odd_to}, {31'd0, m_odd});
            check(even_to === m_even, {req, " even flag"}, {31'd0, even_to}, {31'd0, m_even});
            if (restart) pulses++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = 32'd0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); cfg_raddr = a; #1;
        check(cfg_rdata === e, tag, cfg_rdata, e);
    endtask

    task automatic vpulse(input int hi, input int lo);
        @(negedge clk); vid_vs = 1'b1;
        repeat (hi) @(negedge clk);
        vid_vs = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        req = "R1";
        check(restart === 1'b0, "R1 restart after reset", {31'd0, restart}, 32'd0);
        rd_chk(2'd0, 32'd0, "R1 mode reads 0");
        rd_chk(2'd1, 32'd0, "R1 delay reads 0");
        rd_chk(2'd2, 32'd0, "R1 limits reads 0");
        rd_chk(2'd3, 32'd0, "R1 spare reads 0");

        // R11 register layout
        req = "R11";
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk(2'd1, 32'h001F_FFFF, "R11 delay width");
        wr(2'd2, 32'h0032_001E);
        rd_chk(2'd2, 32'h0032_001E, "R11 limits");
        wr(2'd0, 32'h0000_FFE1);
        rd_chk(2'd0, 32'h0000_0001, "R11 mode bits");
        wr(2'd1, 32'd5);

        // R2 continuous lock timing
        req = "R2";
        pulses = 0;
        repeat (3) vpulse(10, 40);
        check(pulses == 3, "R2 pulse count delay 5", pulses, 3);
        wr(2'd1, 32'd0);
        pulses = 0;
        vpulse(10, 20);
        check(pulses == 1, "R2 pulse count delay 0", pulses, 1);
        wr(2'd1, 32'd20);
        pulses = 0;
        vpulse(10, 40);
        check(pulses == 1, "R2 pulse count delay 20", pulses, 1);

        // R3 falling edge select
        req = "R3";
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h5);
        pulses = 0;
        repeat (2) vpulse(10, 30);
        check(pulses == 2, "R3 falling edge pulses", pulses, 2);
        wr(2'd0, 32'h1);

        // R5 retrigger while pending
        req = "R5";
        wr(2'd1, 32'd20);
        pulses = 0;
        vpulse(3, 3);
        vpulse(3, 40);
        check(pulses == 1, "R5 retrigger single pulse", pulses, 1);

        // R4 display alignment
        req = "R4";
        wr(2'd1, 32'd4);
        pulses = 0;
        @(negedge clk); vid_vs = 1'b1;
        repeat (5) @(negedge clk);
        disp_vs = 1'b1;
        idle(10); vid_vs = 1'b0; disp_vs = 1'b0; idle(20);
        check(pulses == 0, "R4 aligned suppressed", pulses, 0);
        @(negedge clk); vid_vs = 1'b1;
        repeat (2) @(negedge clk);
        disp_vs = 1'b1;
        idle(10); vid_vs = 1'b0; disp_vs = 1'b0; idle(20);
        check(pulses == 1, "R4 misaligned restarts", pulses, 1);

        // R6 single-shot priority
        req = "R6";
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h3);
        pulses = 0;
        repeat (3) vpulse(8, 20);
        check(pulses == 1, "R6 one pulse only", pulses, 1);
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h2);
        pulses = 0;
        repeat (2) vpulse(8, 20);
        check(pulses == 1, "R6 re-armed once", pulses, 1);

        // R7 disabled
        req = "R7";
        wr(2'd0, 32'h0);
        pulses = 0;
        repeat (2) vpulse(8, 20);
        check(pulses == 0, "R7 no pulses disabled", pulses, 0);
        wr(2'd1, 32'd30);
        wr(2'd0, 32'h1);
        vpulse(4, 4);
        wr(2'd0, 32'h0);
        idle(40);
        check(pulses == 0, "R7 pending discarded", pulses, 0);

        // R8 timeout gate
        req = "R8";
        field_odd = 1'b1;
        vpulse(5, 80);
        check(odd_to === 1'b0, "R8 no odd flag", {31'd0, odd_to}, 32'd0);
        rd_chk(2'd0, 32'd0, "R8 flags read 0");

        // R9 per-field timeout
        req = "R9";
        wr(2'd0, 32'h10);
        vpulse(5, 60);
        check(odd_to === 1'b1, "R9 odd flag set", {31'd0, odd_to}, 32'd1);
        check(even_to === 1'b0, "R9 even flag clear", {31'd0, even_to}, 32'd0);
        field_odd = 1'b0;
        repeat (4) vpulse(5, 15);
        check(even_to === 1'b0, "R9 edges keep even quiet", {31'd0, even_to}, 32'd0);
        idle(60);
        check(even_to === 1'b1, "R9 even flag set", {31'd0, even_to}, 32'd1);
        rd_chk(2'd0, 32'h0003_0010, "R9 flags readback");

        // R10 write-one-to-clear
        req = "R10";
        wr(2'd0, 32'h10);
        rd_chk(2'd0, 32'h0003_0010, "R10 write 0 keeps flags");
        wr(2'd0, 32'h0001_0010);
        rd_chk(2'd0, 32'h0002_0010, "R10 odd cleared");
        wr(2'd0, 32'h0002_0010);
        rd_chk(2'd0, 32'h0000_0010, "R10 even cleared");
        idle(5);

        finish_run();
    end

endmodule